// File: doc/BRIEF.md
# Handshaked Output Port Adapter

This block sits between a compute core and one outgoing data port. The core writes a word with a strobe. The adapter puts that word on the port and, depending on the selected mode, marks it with a valid signal, waits for the consumer's acknowledge, or both. While a word is waiting for acknowledge, a stall flag holds the core back. Only one word is ever in flight. There is no queue behind the port.

Three modes are offered. Full handshake raises valid in the same cycle as the write and holds the core until acknowledge. Valid-only gives a one-cycle valid pulse per write and never stalls; it suits the output half of an argument that is both read and written. Acknowledge-only shows no valid to the consumer but still stalls the core until acknowledge. Nothing happens until a start pulse arms the block, and that pulse also captures the mode.

Top module: `port_out_adapter`

## Requirements
- R1: After synchronous active-high reset, `vld_o` and `stall_o` are low and the block is disarmed.
- R2: Before the first accepted start, writes have no effect: `vld_o` and `stall_o` stay low and `dout_o` keeps its reset value of zero.
- R3: In full handshake mode, `vld_o` is high in the same cycle as an accepted write, and `dout_o` shows the written word in that cycle. No word is lost or duplicated.
- R4: In full handshake mode, while the word waits with `ack_i` low, `stall_o` is high from the cycle after the write, and `vld_o` and `dout_o` stay unchanged.
- R5: A cycle with `vld_o` high and `ack_i` high completes the transfer. `vld_o` and `stall_o` are low from the next clock edge. An acknowledge in the write cycle itself completes the transfer with no stall.
- R6: In acknowledge-only mode, `vld_o` is never high. `stall_o` follows the same rule as R4 and R5, and `dout_o` shows the word while it waits.
- R7: In valid-only mode, each write gives a `vld_o` pulse of exactly one cycle. `stall_o` never rises, and `ack_i` has no effect.
- R8: An `ack_i` that arrives while no word is outstanding is ignored: `vld_o` and `stall_o` stay low and `dout_o` keeps the last word.
- R9: A write strobe while `stall_o` is high is ignored, and the outstanding word on `dout_o` is not replaced.
- R10: `mode_i` is encoded as 0 = full handshake, 1 = valid-only, 2 = acknowledge-only, 3 = full handshake. It is captured only by a start pulse in a cycle with `stall_o` low and no write. A start pulse during a stall changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms the block and captures the mode |
| mode_i | input | 2 | Mode code, see R10 |
| wr_i | input | 1 | Write strobe from the core |
| wdata_i | input | DATA_W | Word written by the core |
| stall_o | output | 1 | Core must hold off writing while high |
| dout_o | output | DATA_W | Data toward the consumer |
| vld_o | output | 1 | Word on `dout_o` is valid |
| ack_i | input | 1 | Consumer acknowledge |

## Verification
The bench builds the adapter with `DATA_W` = 16. This width is wide enough that random words rarely repeat, so a lost or duplicated word shows up as a data mismatch in the scoreboard. It is also narrow enough that directed words with distinct hex patterns are easy to trace. Each mode runs with a random acknowledge probability. This produces same-cycle acknowledges, long stalls, back-to-back writes and acknowledges that arrive while the port is idle.

// File: rtl/poa_pkg.sv
package poa_pkg;

    typedef enum logic [1:0] {
        POA_FULL     = 2'd0,
        POA_VONLY    = 2'd1,
        POA_AONLY    = 2'd2,
        POA_FULL_ALT = 2'd3
    } poa_mode_e;

    typedef struct packed {
        logic      armed;
        poa_mode_e mode;
    } poa_ctrl_t;

    // The core is held until the consumer acknowledges.
    function automatic logic needs_ack(input poa_mode_e m);
        return (m != POA_VONLY);
    endfunction

    // A valid signal is shown to the consumer.
    function automatic logic drives_vld(input poa_mode_e m);
        return (m != POA_AONLY);
    endfunction

    // The valid signal stays up until acknowledge, rather than pulsing.
    function automatic logic holds_vld(input poa_mode_e m);
        return (m == POA_FULL) || (m == POA_FULL_ALT);
    endfunction

endpackage

// File: rtl/poa_arm_ctrl.sv
module poa_arm_ctrl
    import poa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  poa_mode_e mode_i,
    input  logic      busy_i,
    input  logic      wr_i,
    output poa_ctrl_t ctrl_o
);

    poa_ctrl_t ctrl_q;
    logic      take_start;

    assign take_start = start_i && !busy_i && !wr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.armed <= 1'b0;
            ctrl_q.mode  <= POA_FULL;
        end else if (take_start) begin
            ctrl_q.armed <= 1'b1;
            ctrl_q.mode  <= mode_i;
        end
    end

    assign ctrl_o = ctrl_q;

    // R10: the mode is frozen while a word is outstanding
    a_r10_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> $stable(ctrl_q.mode));

    // R1: once armed, the block stays armed until reset
    a_r1_arm_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.armed |=> ctrl_q.armed);

endmodule

// File: rtl/poa_hold_reg.sv
module poa_hold_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    logic [DATA_W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)         q_r <= '0;
        else if (load_i) q_r <= d_i;
    end

    assign q_o = q_r;

    // R9: the held word changes only on an accepted write
    a_r9_hold_only_on_load: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_r));

endmodule

// File: rtl/poa_hs_fsm.sv
module poa_hs_fsm
    import poa_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_i,
    input  logic      ack_i,
    input  poa_ctrl_t ctrl_i,
    output logic      accept_o,
    output logic      busy_o
);

    logic busy_q;
    logic accept;

    assign accept = wr_i && ctrl_i.armed && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
        end else if (needs_ack(ctrl_i.mode) && (accept || busy_q)) begin
            busy_q <= !ack_i;
        end else begin
            busy_q <= 1'b0;
        end
    end

    assign accept_o = accept;
    assign busy_o   = busy_q;

    // R4: without acknowledge, the stall persists
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !ack_i) |=> busy_q);

    // R5: an acknowledge releases the stall at the next edge
    a_r5_release: assert property (@(posedge clk) disable iff (rst)
        (busy_q && ack_i) |=> !busy_q);

    // R7: valid-only mode never stalls
    a_r7_vonly_no_stall: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.mode == POA_VONLY) |-> !busy_q);

    // R8: an idle cycle cannot start a stall, whatever ack_i does
    a_r8_idle_ack_ignored: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !wr_i) |=> !busy_q);

endmodule

// File: rtl/port_out_adapter.sv
module port_out_adapter
    import poa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              stall_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              vld_o,
    input  logic              ack_i
);

    poa_ctrl_t         ctrl;
    logic              accept;
    logic              busy;
    logic [DATA_W-1:0] held;

    poa_arm_ctrl u_arm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .mode_i  (poa_mode_e'(mode_i)),
        .busy_i  (busy),
        .wr_i    (wr_i),
        .ctrl_o  (ctrl)
    );

    poa_hs_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr_i),
        .ack_i    (ack_i),
        .ctrl_i   (ctrl),
        .accept_o (accept),
        .busy_o   (busy)
    );

    poa_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .d_i    (wdata_i),
        .q_o    (held)
    );

    always_comb begin
        vld_o = 1'b0;
        if (drives_vld(ctrl.mode)) begin
            vld_o = holds_vld(ctrl.mode) ? (accept || busy) : accept;
        end
    end

    assign dout_o  = accept ? wdata_i : held;
    assign stall_o = busy;

    // R1 / R2: quiet until armed
    a_r1_quiet_until_armed: assert property (@(posedge clk) disable iff (rst)
        !ctrl.armed |-> (!vld_o && !stall_o));

    // R6: acknowledge-only mode never shows valid
    a_r6_aonly_no_vld: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == POA_AONLY) |-> !vld_o);

    // R4: data and valid stay steady while the word waits
    a_r4_data_steady: assert property (@(posedge clk) disable iff (rst)
        (vld_o && !ack_i && holds_vld(ctrl.mode)) |=> (vld_o && $stable(dout_o)));

    // R7: a valid-only pulse lasts one cycle unless another write follows
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (vld_o && ctrl.mode == POA_VONLY) |=> (vld_o == wr_i));

endmodule

// File: tb/tb_port_out_adapter.sv
module tb_port_out_adapter;

    localparam int W = 16;
    localparam int M_FULL  = 0;
    localparam int M_VONLY = 1;
    localparam int M_AONLY = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [1:0]   mode_i = 2'd0;
    logic         wr_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic         stall_o;
    logic [W-1:0] dout_o;
    logic         vld_o;
    logic         ack_i;
    logic         ack_dir = 1'b0;
    logic         ack_rnd = 1'b0;
    logic         cons_en = 1'b0;
    logic         mon_en = 1'b0;
    int           ack_pct = 40;
    int           mode_cur = M_FULL;
    logic         exp_stall = 1'b0;
    int           checks = 0;
    int           errs = 0;
    logic [W-1:0] sb_q[$];

    assign ack_i = cons_en ? ack_rnd : ack_dir;

    always #2.5 clk = ~clk;

    port_out_adapter #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .wr_i(wr_i), .wdata_i(wdata_i), .stall_o(stall_o),
        .dout_o(dout_o), .vld_o(vld_o), .ack_i(ack_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // Consumer: random acknowledge, redrawn every cycle
    always @(posedge clk) begin
        #1;
        ack_rnd = ($urandom_range(99) < ack_pct);
    end

    // Monitor: pops the scoreboard on each completed transfer
    always @(negedge clk) begin
        if (mon_en) begin
            logic offered;
            logic xfer;
            offered = (mode_cur == M_AONLY) ? (wr_i || stall_o) : vld_o;
            chk("R4/R5 stall timing", stall_o, exp_stall);
            if (mode_cur == M_FULL)  chk("R3 valid with write or wait", vld_o, wr_i || stall_o);
            if (mode_cur == M_AONLY) chk("R6 no valid", vld_o, 1'b0);
            if (mode_cur == M_VONLY) begin
                chk("R7 one pulse per write", vld_o, wr_i);
                chk("R7 never stalls", stall_o, 1'b0);
            end
            xfer = (mode_cur == M_VONLY) ? vld_o : (offered && ack_i);
            if (xfer) begin
                if (sb_q.size() == 0) chk("R3 duplicated word", 1, 0);
                else                  chk("R3 word order", dout_o, sb_q.pop_front());
            end
            exp_stall = (mode_cur != M_VONLY) && offered && !ack_i;
        end
    end

    task automatic push_word(input logic [W-1:0] d);
        while (stall_o) cyc();
        wr_i    = 1'b1;
        wdata_i = d;
        sb_q.push_back(d);
        cyc();
        wr_i = 1'b0;
    endtask

    task automatic arm(input logic [1:0] m);
        ack_dir = 1'b0;
        start_i = 1'b1;
        mode_i  = m;
        cyc();
        start_i = 1'b0;
    endtask

    task automatic random_phase(input int n, input int pct);
        exp_stall = 1'b0;
        ack_pct = pct;
        cons_en = 1'b1;
        mon_en  = 1'b1;
        for (int i = 0; i < n; i++) begin
            int gap;
            push_word(W'($urandom));
            gap = $urandom_range(2);
            for (int g = 0; g < gap; g++) cyc();
        end
        for (int t = 0; t < 2000 && sb_q.size() != 0; t++) cyc();
        chk("R3 no word lost", sb_q.size(), 0);
        while (stall_o) cyc();
        mon_en  = 1'b0;
        cons_en = 1'b0;
        cyc();
        sb_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        @(negedge clk);
        chk("R1 reset vld", vld_o, 0);
        chk("R1 reset stall", stall_o, 0);
        cyc();
        rst = 1'b0;

        // R2: write before start is ignored
        wr_i = 1'b1; wdata_i = 16'hAAAA;
        @(negedge clk);
        chk("R2 no valid before start", vld_o, 0);
        cyc();
        wr_i = 1'b0;
        @(negedge clk);
        chk("R2 no stall before start", stall_o, 0);
        chk("R2 data untouched", dout_o, 0);
        cyc();

        arm(2'd0);
        // R3 / R4 / R9 / R10 in full handshake mode
        wr_i = 1'b1; wdata_i = 16'h1111; ack_dir = 1'b0;
        @(negedge clk);
        chk("R3 valid same cycle", vld_o, 1);
        chk("R3 data same cycle", dout_o, 16'h1111);
        cyc();
        wdata_i = 16'h2222; start_i = 1'b1; mode_i = 2'd1;
        @(negedge clk);
        chk("R4 stalled", stall_o, 1);
        chk("R4 valid held", vld_o, 1);
        chk("R9 word kept", dout_o, 16'h1111);
        cyc();
        wr_i = 1'b0; start_i = 1'b0; ack_dir = 1'b1;
        @(negedge clk);
        chk("R5 stall until edge", stall_o, 1);
        chk("R9 word still kept", dout_o, 16'h1111);
        cyc();
        ack_dir = 1'b0;
        @(negedge clk);
        chk("R5 valid dropped", vld_o, 0);
        chk("R5 stall released", stall_o, 0);
        cyc();
        wr_i = 1'b1; wdata_i = 16'h3333;
        cyc();
        wr_i = 1'b0;
        @(negedge clk);
        chk("R10 start during stall ignored", stall_o, 1);
        cyc();
        ack_dir = 1'b1;
        cyc();
        @(negedge clk);
        chk("R8 idle ack no valid", vld_o, 0);
        chk("R8 idle ack no stall", stall_o, 0);
        chk("R8 idle ack data kept", dout_o, 16'h3333);
        cyc();
        ack_dir = 1'b1; wr_i = 1'b1; wdata_i = 16'h4444;
        @(negedge clk);
        chk("R5 same-cycle ack valid", vld_o, 1);
        cyc();
        wr_i = 1'b0; ack_dir = 1'b0;
        @(negedge clk);
        chk("R5 same-cycle ack no stall", stall_o, 0);
        chk("R5 same-cycle ack valid low", vld_o, 0);
        cyc();

        mode_cur = M_FULL;
        random_phase(250, 35);

        // R7 valid-only
        arm(2'd1);
        ack_dir = 1'b1; wr_i = 1'b1; wdata_i = 16'h5555;
        @(negedge clk);
        chk("R7 pulse high", vld_o, 1);
        cyc();
        wr_i = 1'b0;
        @(negedge clk);
        chk("R7 pulse one cycle", vld_o, 0);
        chk("R7 no stall", stall_o, 0);
        cyc();
        ack_dir = 1'b0;
        mode_cur = M_VONLY;
        random_phase(250, 50);

        // R6 acknowledge-only
        arm(2'd2);
        wr_i = 1'b1; wdata_i = 16'h6666;
        @(negedge clk);
        chk("R6 no valid on write", vld_o, 0);
        chk("R6 data shown", dout_o, 16'h6666);
        cyc();
        wr_i = 1'b0;
        @(negedge clk);
        chk("R6 stalled", stall_o, 1);
        cyc();
        ack_dir = 1'b1;
        @(negedge clk);
        chk("R6 stall until edge", stall_o, 1);
        cyc();
        ack_dir = 1'b0;
        @(negedge clk);
        chk("R6 released", stall_o, 0);
        cyc();
        mode_cur = M_AONLY;
        random_phase(250, 30);

        // R10 code 3 behaves as full handshake
        arm(2'd3);
        mode_cur = M_FULL;
        random_phase(100, 40);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule